// File: doc/BRIEF.md
# PWM Pair Emergency Shutdown Controller

This block protects a complementary pair of PWM output pins. It watches a set of fault sources and, when any of them is both latched and allowed to act, releases the output enables of both pins so that the pads go to high impedance. The sources are:

- a main external fault input
- a detector for both pair outputs being active at once
- a software shutdown bit
- two auxiliary external fault inputs
- three analog comparator trip lines
- an oscillator-stop indication

Every hardware source is captured in a sticky flag on its rising detection. Software clears a flag by writing 0 to its bit, and the flag is kept while its cause is still present. Each flag is then gated by its own enable structure. A master group enable stands over all of them.

Control is a small state machine with two states. ST_RUN drives both pins. ST_HIZ releases both output enables. The transition T_TRIP goes from ST_RUN to ST_HIZ on the first clock edge at which the gated request is high. The transition T_RELEASE goes from ST_HIZ back to ST_RUN on the first edge at which the request is low. While neither applies, the machine stays in its state. The request is low once every contributing flag and the software bit are cleared, or once the group enable drops.

Top module: `pwm_pair_shutdown`

## Requirements
- R1: While the group enable (control register, address 0, bit 0) is 0, both `oe_hi` and `oe_lo` stay 1 whatever the flags and the software bit hold. Clearing it while tripped returns the pins to driven on the next edge.
- R2: The main fault flag (`fault_flags` bit 0, set by `fault_main`) trips the pair with no source enable beyond the group enable.
- R3: The overlap flag (`fault_flags` bit 1) sets when `pwm_hi` and `pwm_lo` are both at the active level (1) in the same cycle. It trips the pair only while the overlap enable (address 0, bit 1) is 1. Alternating complementary patterns never set it.
- R4: The software shutdown bit (address 0, bit 2) trips the pair while it is 1.
- R5: Auxiliary flag 1 (`fault_flags` bit 2) trips only when address 0 bits 3 (add) and 4 (detect) are both 1. Auxiliary flag 2 (`fault_flags` bit 3) trips only when address 0 bits 5 and 6 are both 1.
- R6: Comparator flag k (`fault_flags` bit 5+k, k = 0..2) trips only when the shared comparator enable (address 1, bit 0) and that comparator's select bit (address 1, bit 1+k) are both 1.
- R7: The oscillator-stop flag (`fault_flags` bit 4) trips only while address 0 bit 7 is 1.
- R8: Once a gated flag is set, both output enables go to 0 together on the next clock edge and stay equal at all times.
- R9: A flag sets only on a rising detection of its cause. It clears only when software writes 0 to its bit at address 2. Writing 1 to a flag bit leaves it unchanged.
- R10: A write of 0 to a flag bit has no effect while that flag's cause is still active.
- R11: After a trip, the pins return to driven only once every contributing gated flag and the software bit are cleared. Clearing one of two contributors keeps the pair tripped.
- R12: After reset, all flags and enables are 0 and both output enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Write address: 0 control, 1 comparator routing, 2 flag clear |
| cfg_wdata | input | 8 | Write data |
| fault_main | input | 1 | Main external fault, active high |
| fault_aux1 | input | 1 | Auxiliary external fault 1, active high |
| fault_aux2 | input | 1 | Auxiliary external fault 2, active high |
| cmp_trip | input | 3 | Analog comparator trip lines, active high |
| osc_stopped | input | 1 | Oscillator-stop indication, active high |
| pwm_hi | input | 1 | High-side PWM output of the pair |
| pwm_lo | input | 1 | Low-side PWM output of the pair |
| oe_hi | output | 1 | High-side pin output enable (0 = high impedance) |
| oe_lo | output | 1 | Low-side pin output enable (0 = high impedance) |
| fault_flags | output | 8 | Sticky fault flags |

## Verification
Each gated source is first pulsed with its enable structure incomplete (only one of two enables, the wrong comparator selected, or the group enable off), then with it complete. This separates a flag that latches from a flag that is allowed to act. The pair outputs are driven both with alternating complementary patterns and with a single overlap cycle, which separates a true overlap from ordinary switching. Clear writes are issued with the cause held high, with 1 in the flag bit, and with two contributors latched and only one cleared. These cases separate a correct sticky flag and release rule from a flag that clears too early or a release that happens too soon. A reference model in the bench follows every edge, so the one-cycle trip and release timing is compared on every clock.

// File: rtl/pwm_sd_pkg.sv
package pwm_sd_pkg;

    // Flag vector positions
    localparam int unsigned FLG_MAIN = 0;
    localparam int unsigned FLG_OVL  = 1;
    localparam int unsigned FLG_AUX1 = 2;
    localparam int unsigned FLG_AUX2 = 3;
    localparam int unsigned FLG_OSC  = 4;
    localparam int unsigned FLG_CMP0 = 5;
    localparam int unsigned NUM_FIXED_FLAGS = 5;

    // Register addresses
    localparam int unsigned ADDR_CTRL  = 0;
    localparam int unsigned ADDR_CMP   = 1;
    localparam int unsigned ADDR_FLAGS = 2;

    // Control register bit positions
    localparam int unsigned CB_GRP  = 0;
    localparam int unsigned CB_OVL  = 1;
    localparam int unsigned CB_SW   = 2;
    localparam int unsigned CB_ADD1 = 3;
    localparam int unsigned CB_DET1 = 4;
    localparam int unsigned CB_ADD2 = 5;
    localparam int unsigned CB_DET2 = 6;
    localparam int unsigned CB_OSC  = 7;

    typedef struct packed {
        logic grp_en;
        logic ovl_en;
        logic sw_hiz;
        logic add1_en;
        logic det1_en;
        logic add2_en;
        logic det2_en;
        logic osc_en;
    } sd_ctrl_t;

    typedef enum logic [0:0] {
        ST_RUN = 1'b0,
        ST_HIZ = 1'b1
    } sd_state_e;

endpackage

// File: rtl/pwm_sd_cfg_regs.sv
module pwm_sd_cfg_regs
    import pwm_sd_pkg::*;
#(
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned NUM_CMP   = 3,
    parameter int unsigned NUM_FLAGS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output sd_ctrl_t             ctrl_q,
    output logic                 cmp_add_q,
    output logic [NUM_CMP-1:0]   cmp_sel_q,
    output logic [NUM_FLAGS-1:0] clr_req
);

    logic wr_ctrl;
    logic wr_cmp;
    logic wr_flags;

    assign wr_ctrl  = cfg_we && (cfg_addr == ADDR_W'(ADDR_CTRL));
    assign wr_cmp   = cfg_we && (cfg_addr == ADDR_W'(ADDR_CMP));
    assign wr_flags = cfg_we && (cfg_addr == ADDR_W'(ADDR_FLAGS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.grp_en  <= cfg_wdata[CB_GRP];
            ctrl_q.ovl_en  <= cfg_wdata[CB_OVL];
            ctrl_q.sw_hiz  <= cfg_wdata[CB_SW];
            ctrl_q.add1_en <= cfg_wdata[CB_ADD1];
            ctrl_q.det1_en <= cfg_wdata[CB_DET1];
            ctrl_q.add2_en <= cfg_wdata[CB_ADD2];
            ctrl_q.det2_en <= cfg_wdata[CB_DET2];
            ctrl_q.osc_en  <= cfg_wdata[CB_OSC];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_add_q <= 1'b0;
            cmp_sel_q <= '0;
        end else if (wr_cmp) begin
            cmp_add_q <= cfg_wdata[0];
            cmp_sel_q <= cfg_wdata[NUM_CMP:1];
        end
    end

    // A zero written into a flag bit asks for that flag to be cleared
    always_comb begin
        clr_req = '0;
        if (wr_flags) begin
            clr_req = ~cfg_wdata[NUM_FLAGS-1:0];
        end
    end

endmodule

// File: rtl/pwm_sd_fault_flag.sv
module pwm_sd_fault_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic cause,
    input  logic clr_req,
    output logic flag_q
);

    logic cause_d;
    logic rise;

    assign rise = cause && !cause_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_d <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            cause_d <= cause;
            if (rise) begin
                flag_q <= 1'b1;
            end else if (clr_req && !cause) begin
                flag_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pwm_sd_req_gate.sv
module pwm_sd_req_gate
    import pwm_sd_pkg::*;
#(
    parameter int unsigned NUM_CMP   = 3,
    parameter int unsigned NUM_FLAGS = 8
) (
    input  logic [NUM_FLAGS-1:0] flags,
    input  sd_ctrl_t             ctrl,
    input  logic                 cmp_add,
    input  logic [NUM_CMP-1:0]   cmp_sel,
    output logic                 req
);

    logic [NUM_FLAGS-1:0] hit;

    always_comb begin
        hit           = '0;
        hit[FLG_MAIN] = flags[FLG_MAIN];
        hit[FLG_OVL]  = flags[FLG_OVL]  && ctrl.ovl_en;
        hit[FLG_AUX1] = flags[FLG_AUX1] && ctrl.add1_en && ctrl.det1_en;
        hit[FLG_AUX2] = flags[FLG_AUX2] && ctrl.add2_en && ctrl.det2_en;
        hit[FLG_OSC]  = flags[FLG_OSC]  && ctrl.osc_en;
        for (int k = 0; k < int'(NUM_CMP); k++) begin
            hit[FLG_CMP0 + k] = flags[FLG_CMP0 + k] && cmp_add && cmp_sel[k];
        end
    end

    assign req = ctrl.grp_en && ((|hit) || ctrl.sw_hiz);

endmodule

// File: rtl/pwm_pair_shutdown.sv
module pwm_pair_shutdown
    import pwm_sd_pkg::*;
#(
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned NUM_CMP = 3,
    parameter logic        ACT_LVL = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [ADDR_W-1:0]            cfg_addr,
    input  logic [DATA_W-1:0]            cfg_wdata,
    input  logic                         fault_main,
    input  logic                         fault_aux1,
    input  logic                         fault_aux2,
    input  logic [NUM_CMP-1:0]           cmp_trip,
    input  logic                         osc_stopped,
    input  logic                         pwm_hi,
    input  logic                         pwm_lo,
    output logic                         oe_hi,
    output logic                         oe_lo,
    output logic [NUM_FIXED_FLAGS+NUM_CMP-1:0] fault_flags
);

    localparam int unsigned NUM_FLAGS = NUM_FIXED_FLAGS + NUM_CMP;

    sd_ctrl_t             ctrl_q;
    logic                 cmp_add_q;
    logic [NUM_CMP-1:0]   cmp_sel_q;
    logic [NUM_FLAGS-1:0] clr_req;
    logic [NUM_FLAGS-1:0] raw;
    logic [NUM_FLAGS-1:0] flags_q;
    logic                 overlap;
    logic                 req;
    logic                 grp_en_w;
    logic                 sw_hiz_w;
    sd_state_e            state_q;
    sd_state_e            state_d;

    assign grp_en_w = ctrl_q.grp_en;
    assign sw_hiz_w = ctrl_q.sw_hiz;

    pwm_sd_cfg_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NUM_CMP   (NUM_CMP),
        .NUM_FLAGS (NUM_FLAGS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ctrl_q    (ctrl_q),
        .cmp_add_q (cmp_add_q),
        .cmp_sel_q (cmp_sel_q),
        .clr_req   (clr_req)
    );

    // Both legs of the complementary pair active in one cycle
    assign overlap = (pwm_hi == ACT_LVL) && (pwm_lo == ACT_LVL);

    always_comb begin
        raw           = '0;
        raw[FLG_MAIN] = fault_main;
        raw[FLG_OVL]  = overlap;
        raw[FLG_AUX1] = fault_aux1;
        raw[FLG_AUX2] = fault_aux2;
        raw[FLG_OSC]  = osc_stopped;
        for (int k = 0; k < int'(NUM_CMP); k++) begin
            raw[FLG_CMP0 + k] = cmp_trip[k];
        end
    end

    for (genvar i = 0; i < int'(NUM_FLAGS); i++) begin : g_flag
        pwm_sd_fault_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .cause   (raw[i]),
            .clr_req (clr_req[i]),
            .flag_q  (flags_q[i])
        );
    end

    pwm_sd_req_gate #(
        .NUM_CMP   (NUM_CMP),
        .NUM_FLAGS (NUM_FLAGS)
    ) u_gate (
        .flags   (flags_q),
        .ctrl    (ctrl_q),
        .cmp_add (cmp_add_q),
        .cmp_sel (cmp_sel_q),
        .req     (req)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: T_TRIP and T_RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: if (req)  state_d = ST_HIZ;
            ST_HIZ: if (!req) state_d = ST_RUN;
            default:          state_d = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        oe_hi = 1'b1;
        oe_lo = 1'b1;
        unique case (state_q)
            ST_RUN: begin
                oe_hi = 1'b1;
                oe_lo = 1'b1;
            end
            ST_HIZ: begin
                oe_hi = 1'b0;
                oe_lo = 1'b0;
            end
            default: begin
                oe_hi = 1'b1;
                oe_lo = 1'b1;
            end
        endcase
    end

    assign fault_flags = flags_q;

endmodule

// File: rtl/pwm_sd_checker.sv
module pwm_sd_checker #(
    parameter int unsigned NUM_FLAGS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 grp_en,
    input logic                 sw_hiz,
    input logic                 req,
    input logic [NUM_FLAGS-1:0] flags,
    input logic [NUM_FLAGS-1:0] raw,
    input logic [NUM_FLAGS-1:0] clr_req,
    input logic                 oe_hi,
    input logic                 oe_lo
);

    a_r1_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_en |=> (oe_hi && oe_lo));

    a_r2_main_trips: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_en && flags[0]) |=> (!oe_hi && !oe_lo));

    a_r4_soft_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_en && sw_hiz) |=> (!oe_hi && !oe_lo));

    a_r8_pair_equal: assert property (@(posedge clk) disable iff (!rst_n)
        oe_hi == oe_lo);

    a_r8_trip_next: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !oe_hi);

    a_r11_release_next: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> oe_hi);

    for (genvar i = 0; i < int'(NUM_FLAGS); i++) begin : g_bit
        a_r9_rise_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[i]) |-> $past(raw[i]));

        a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[i]) |-> $past(clr_req[i]));

        a_r10_hold_while_active: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(raw[i]) && $past(flags[i])) |-> flags[i]);
    end

endmodule

bind pwm_pair_shutdown pwm_sd_checker #(
    .NUM_FLAGS (NUM_FLAGS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .grp_en  (grp_en_w),
    .sw_hiz  (sw_hiz_w),
    .req     (req),
    .flags   (flags_q),
    .raw     (raw),
    .clr_req (clr_req),
    .oe_hi   (oe_hi),
    .oe_lo   (oe_lo)
);

// File: tb/pwm_pair_shutdown_tb.sv
`timescale 1ns/1ps
module pwm_pair_shutdown_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       fault_main = 1'b0;
    logic       fault_aux1 = 1'b0;
    logic       fault_aux2 = 1'b0;
    logic [2:0] cmp_trip = '0;
    logic       osc_stopped = 1'b0;
    logic       pwm_hi = 1'b0;
    logic       pwm_lo = 1'b0;
    logic       oe_hi;
    logic       oe_lo;
    logic [7:0] fault_flags;

    int    errors = 0;
    int    checks = 0;
    string tag = "R12";
    bit    done = 1'b0;

    always #10 clk = ~clk;

    pwm_pair_shutdown u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .fault_main  (fault_main),
        .fault_aux1  (fault_aux1),
        .fault_aux2  (fault_aux2),
        .cmp_trip    (cmp_trip),
        .osc_stopped (osc_stopped),
        .pwm_hi      (pwm_hi),
        .pwm_lo      (pwm_lo),
        .oe_hi       (oe_hi),
        .oe_lo       (oe_lo),
        .fault_flags (fault_flags)
    );

    // Reference model state
    bit [7:0] m_ctrl;
    bit [3:0] m_cmp;
    bit [7:0] m_flag;
    bit [7:0] m_prev;
    bit       m_hiz;

    function automatic bit model_req();
        bit any;
        any = m_flag[0];
        if (m_flag[1] && m_ctrl[1]) any = 1'b1;
        if (m_flag[2] && m_ctrl[3] && m_ctrl[4]) any = 1'b1;
        if (m_flag[3] && m_ctrl[5] && m_ctrl[6]) any = 1'b1;
        if (m_flag[4] && m_ctrl[7]) any = 1'b1;
        for (int k = 0; k < 3; k++) begin
            if (m_flag[5+k] && m_cmp[0] && m_cmp[1+k]) any = 1'b1;
        end
        if (m_ctrl[2]) any = 1'b1;
        return m_ctrl[0] && any;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = '0;
            m_cmp  = '0;
            m_flag = '0;
            m_prev = '0;
            m_hiz  = 1'b0;
        end else begin
            bit [7:0] cause;
            m_hiz = model_req();
            cause = {cmp_trip, osc_stopped, fault_aux2, fault_aux1,
                     (pwm_hi && pwm_lo), fault_main};
            for (int i = 0; i < 8; i++) begin
                if (cause[i] && !m_prev[i]) begin
                    m_flag[i] = 1'b1;
                end else if (cfg_we && cfg_addr == 2'd2 && !cfg_wdata[i] && !cause[i]) begin
                    m_flag[i] = 1'b0;
                end
            end
            m_prev = cause;
            if (cfg_we && cfg_addr == 2'd0) m_ctrl = cfg_wdata;
            if (cfg_we && cfg_addr == 2'd1) m_cmp  = cfg_wdata[3:0];
        end
    end

    task automatic check(input bit ok, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            check((oe_hi === !m_hiz) && (oe_lo === !m_hiz),
                  int'({oe_hi, oe_lo}), int'({!m_hiz, !m_hiz}), "output enables");
            check(fault_flags === m_flag, int'(fault_flags), int'(m_flag), "flags");
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit [1:0] a, input bit [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clr(input bit [7:0] mask);
        wr(2'd2, ~mask);
    endtask

    // Cause pattern: bit0 main, bit1 overlap, bit2 aux1, bit3 aux2, bit4 osc, bits7:5 comparators
    task automatic set_cause(input bit [7:0] v);
        @(negedge clk);
        fault_main  = v[0];
        pwm_hi      = 1'b1;
        pwm_lo      = v[1];
        fault_aux1  = v[2];
        fault_aux2  = v[3];
        osc_stopped = v[4];
        cmp_trip    = v[7:5];
    endtask

    task automatic pulse(input bit [7:0] v);
        set_cause(v);
        set_cause(8'h00);
        idle(2);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog %s: actual=hung expected=finished", tag);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        tag = "R12";
        idle(3);
        rst_n = 1'b1;
        idle(3);

        // R1: group enable off blocks every source
        tag = "R1";
        pulse(8'h01);
        wr(2'd0, 8'h04);
        idle(2);
        wr(2'd0, 8'h00);
        clr(8'h01);
        idle(2);

        // R2: main flag trips with only the group enable
        tag = "R2";
        wr(2'd0, 8'h01);
        pulse(8'h01);
        idle(2);
        clr(8'h01);
        idle(2);

        // R3: overlap detection and its enable
        tag = "R3";
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            pwm_hi = j[0];
            pwm_lo = !j[0];
        end
        @(negedge clk);
        pwm_hi = 1'b0;
        pwm_lo = 1'b0;
        idle(2);
        pulse(8'h02);
        wr(2'd0, 8'h03);
        idle(2);
        clr(8'h02);
        idle(2);

        // R4: software shutdown bit
        tag = "R4";
        wr(2'd0, 8'h05);
        idle(3);
        wr(2'd0, 8'h01);
        idle(3);

        // R5: auxiliary inputs need both enables
        tag = "R5";
        wr(2'd0, 8'h09);
        pulse(8'h04);
        wr(2'd0, 8'h11);
        idle(2);
        wr(2'd0, 8'h19);
        idle(2);
        clr(8'h04);
        idle(2);
        wr(2'd0, 8'h21);
        pulse(8'h08);
        wr(2'd0, 8'h41);
        idle(2);
        wr(2'd0, 8'h61);
        idle(2);
        clr(8'h08);
        idle(2);

        // R6: comparator routing
        tag = "R6";
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h03);
        pulse(8'h40);
        wr(2'd1, 8'h04);
        idle(2);
        wr(2'd1, 8'h05);
        idle(2);
        clr(8'h40);
        idle(2);
        wr(2'd1, 8'h09);
        pulse(8'h80);
        clr(8'h80);
        idle(2);
        wr(2'd1, 8'h03);
        pulse(8'h20);
        clr(8'h20);
        wr(2'd1, 8'h00);
        idle(2);

        // R7: oscillator stop needs its enable
        tag = "R7";
        pulse(8'h10);
        wr(2'd0, 8'h81);
        idle(2);
        clr(8'h10);
        wr(2'd0, 8'h01);
        idle(2);

        // R8: trip one edge after the flag is set, held cause
        tag = "R8";
        set_cause(8'h01);
        idle(4);

        // R10: clear blocked while the cause is active
        tag = "R10";
        clr(8'h01);
        idle(2);
        set_cause(8'h00);
        idle(1);
        clr(8'h01);
        idle(2);

        // R9: writing 1 or clearing another bit leaves a flag set
        tag = "R9";
        pulse(8'h01);
        wr(2'd2, 8'hFF);
        idle(2);
        clr(8'h02);
        idle(2);
        clr(8'h01);
        idle(2);

        // R11: release only after every contributor is cleared
        tag = "R11";
        wr(2'd0, 8'h83);
        pulse(8'h13);
        clr(8'h01);
        idle(2);
        clr(8'h02);
        idle(2);
        wr(2'd0, 8'h87);
        clr(8'h10);
        idle(2);
        wr(2'd0, 8'h83);
        idle(2);

        // R1: dropping the group enable while tripped
        tag = "R1";
        pulse(8'h01);
        wr(2'd0, 8'h00);
        idle(2);
        wr(2'd0, 8'h01);
        idle(2);
        clr(8'h01);
        idle(3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule